// File: doc/BRIEF.md
# Multi-Mode Low-Power Planner

This block sits beside a memory controller and decides when the memory subsystem should drop into a power-saving mode, and which one. Four independent observers, each tuned to one depth of power-saving mode with its own slot length and threshold, each raise a recommendation bit. The planner picks the deepest mode that is currently recommended. It asks the controller to enter that mode only when every memory channel reports idle in the same cycle.

Toward the controller it drives a plain enter/exit handshake. A request is a level that stays high until the controller answers with an acknowledge. `enter_req` and `exit_req` work like a valid signal, and `lp_ack` works like ready. A request, and the mode code that goes with it, may not change or drop while it waits. Any channel becoming busy while the memory rests in a mode triggers an exit. A deeper recommendation arriving during residence also triggers an exit, and the planner then re-enters at the deeper level, so it never jumps directly from one mode to another. A one-cycle wake pulse marks each completed exit, for use by threshold feedback logic elsewhere.

Top module: `lp_planner`

## Requirements
- R1: After reset `enter_req`, `exit_req` and `wake_pulse` are low and `req_mode` is 0.
- R2: An entry request starts only after a cycle in which every bit of `ch_idle` is 1 and at least one bit of `mode_rec` is 1. If any channel is busy, nothing is requested.
- R3: `mode_rec` bit i recommends mode i+1, and a higher index is a deeper mode. `req_mode` is a 3-bit code equal to 1 plus the highest set index, and 0 means no mode.
- R4: `enter_req` stays high with a stable `req_mode` until a cycle in which `lp_ack` is 1. It is low in the cycle after that.
- R5: While an entry is pending, changes on `mode_rec` do not alter `req_mode`.
- R6: While resident in a mode, a cycle with any `ch_idle` bit at 0 raises `exit_req` on the next cycle.
- R7: `exit_req` stays high until acknowledged. In the cycle after the acknowledge, `wake_pulse` is high for exactly one cycle and `req_mode` returns to 0.
- R8: While resident, a recommendation for a deeper mode causes an exit followed by a new entry with the deeper code. A shallower or equal recommendation causes no exit.
- R9: `enter_req` and `exit_req` are never high together.
- R10: `lp_ack` while no request is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_idle | input | NUM_CH | Per-channel idle indication |
| mode_rec | input | NUM_MODES | Per-mode observer recommendation, bit i = mode i+1 |
| lp_ack | input | 1 | Controller acknowledge of the pending enter or exit request |
| enter_req | output | 1 | Request to enter mode `req_mode`, held until acknowledged |
| exit_req | output | 1 | Request to leave the current mode, held until acknowledged |
| req_mode | output | 3 | Code of the requested or resident mode, 0 when none |
| wake_pulse | output | 1 | One-cycle pulse after each acknowledged exit |

## Verification
The hardest situation to reach from the ports is deepening during residence. The bench first has to complete an entry at a shallow level. It then has to raise a deeper recommendation while keeping all channels idle, so that the exit is caused by the recommendation and not by traffic. The stimulus gets there by changing the recommendation while the entry request is still pending, which also shows that the pending code is latched. It then acknowledges the entry, acknowledges the exit that follows, and watches the planner re-enter at the deeper code in the cycle after the wake pulse.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    PL_IDLE   = 2'd0,
    PL_ENTER  = 2'd1,
    PL_RESIDE = 2'd2,
    PL_EXIT   = 2'd3
  } pl_state_e;
endpackage

// File: rtl/lp_idle_gate.sv
module lp_idle_gate #(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] ch_idle,
  output logic              all_idle
);
  logic [NUM_CH:0] chain;
  assign chain[0] = 1'b1;
  for (genvar g = 0; g < NUM_CH; g++) begin : g_and
    assign chain[g+1] = chain[g] & ch_idle[g];
  end
  assign all_idle = chain[NUM_CH];
endmodule

// File: rtl/lp_deepest_pick.sv
module lp_deepest_pick #(
  parameter int NUM_MODES = 4,
  parameter int CODE_W    = 3
) (
  input  logic [NUM_MODES-1:0] mode_rec,
  output logic [CODE_W-1:0]    pick
);
  logic [CODE_W-1:0] stage [NUM_MODES+1];
  assign stage[0] = '0;
  for (genvar g = 0; g < NUM_MODES; g++) begin : g_prio
    assign stage[g+1] = mode_rec[g] ? CODE_W'(g + 1) : stage[g];
  end
  assign pick = stage[NUM_MODES];
endmodule

// File: rtl/lp_hs_fsm.sv
module lp_hs_fsm
  import lp_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              all_idle,
  input  logic [CODE_W-1:0] pick,
  input  logic              ack,
  output logic              enter_req,
  output logic              exit_req,
  output logic [CODE_W-1:0] mode_code,
  output logic              wake
);
  pl_state_e         state_q, state_d;
  logic [CODE_W-1:0] mode_q, mode_d;
  logic              wake_q, wake_d;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    wake_d  = 1'b0;
    unique case (state_q)
      PL_IDLE: begin
        if (all_idle && pick != '0) begin
          state_d = PL_ENTER;
          mode_d  = pick;
        end
      end
      PL_ENTER: begin
        if (ack) state_d = PL_RESIDE;
      end
      PL_RESIDE: begin
        if (!all_idle || pick > mode_q) state_d = PL_EXIT;
      end
      PL_EXIT: begin
        if (ack) begin
          state_d = PL_IDLE;
          mode_d  = '0;
          wake_d  = 1'b1;
        end
      end
      default: state_d = PL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PL_IDLE;
      mode_q  <= '0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      wake_q  <= wake_d;
    end
  end

  assign enter_req = (state_q == PL_ENTER);
  assign exit_req  = (state_q == PL_EXIT);
  assign mode_code = mode_q;
  assign wake      = wake_q;
endmodule

// File: rtl/lp_planner.sv
module lp_planner #(
  parameter int NUM_CH    = 2,
  parameter int NUM_MODES = 4,
  parameter int CODE_W    = $clog2(NUM_MODES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    ch_idle,
  input  logic [NUM_MODES-1:0] mode_rec,
  input  logic                 lp_ack,
  output logic                 enter_req,
  output logic                 exit_req,
  output logic [CODE_W-1:0]    req_mode,
  output logic                 wake_pulse
);
  logic              all_idle;
  logic [CODE_W-1:0] pick;

  lp_idle_gate #(.NUM_CH(NUM_CH)) u_gate (
    .ch_idle  (ch_idle),
    .all_idle (all_idle)
  );

  lp_deepest_pick #(.NUM_MODES(NUM_MODES), .CODE_W(CODE_W)) u_pick (
    .mode_rec (mode_rec),
    .pick     (pick)
  );

  lp_hs_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .all_idle  (all_idle),
    .pick      (pick),
    .ack       (lp_ack),
    .enter_req (enter_req),
    .exit_req  (exit_req),
    .mode_code (req_mode),
    .wake      (wake_pulse)
  );
endmodule

// File: rtl/lp_planner_chk.sv
module lp_planner_chk #(
  parameter int NUM_CH    = 2,
  parameter int NUM_MODES = 4,
  parameter int CODE_W    = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CH-1:0]    ch_idle,
  input logic [NUM_MODES-1:0] mode_rec,
  input logic                 lp_ack,
  input logic                 enter_req,
  input logic                 exit_req,
  input logic [CODE_W-1:0]    req_mode,
  input logic                 wake_pulse
);
  assert_no_dual_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter_req && exit_req));

  assert_enter_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && !lp_ack) |=> (enter_req && $stable(req_mode)));

  assert_enter_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && lp_ack) |=> !enter_req);

  assert_exit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req && !lp_ack) |=> exit_req);

  assert_wake_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req && lp_ack) |=> (wake_pulse && req_mode == '0));

  assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  assert_entry_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enter_req) |-> $past((&ch_idle) && (|mode_rec)));

  assert_exit_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exit_req) |-> $past(!(&ch_idle) || ((mode_rec >> req_mode) != '0)));
endmodule

bind lp_planner lp_planner_chk #(
  .NUM_CH(NUM_CH), .NUM_MODES(NUM_MODES), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_idle(ch_idle), .mode_rec(mode_rec),
  .lp_ack(lp_ack), .enter_req(enter_req), .exit_req(exit_req),
  .req_mode(req_mode), .wake_pulse(wake_pulse)
);

// File: tb/lp_planner_test.sv
`timescale 1ns/1ps
module lp_planner_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ch_idle = 2'b00;
  logic [3:0] mode_rec = 4'b0000;
  logic       lp_ack = 1'b0;
  logic       enter_req, exit_req, wake_pulse;
  logic [2:0] req_mode;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lp_planner uut (
    .clk(clk), .rst_n(rst_n), .ch_idle(ch_idle), .mode_rec(mode_rec),
    .lp_ack(lp_ack), .enter_req(enter_req), .exit_req(exit_req),
    .req_mode(req_mode), .wake_pulse(wake_pulse)
  );

  // {ch_idle, mode_rec, expected code}
  localparam logic [8:0] VEC [11] = '{
    {2'b11, 4'b0000, 3'd0}, {2'b11, 4'b0001, 3'd1}, {2'b11, 4'b0010, 3'd2},
    {2'b11, 4'b0100, 3'd3}, {2'b11, 4'b1000, 3'd4}, {2'b11, 4'b0101, 3'd3},
    {2'b11, 4'b1111, 3'd4}, {2'b11, 4'b0110, 3'd3}, {2'b01, 4'b1111, 3'd0},
    {2'b10, 4'b1000, 3'd0}, {2'b00, 4'b0001, 3'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic leave_mode();
    lp_ack = 1'b1; mode_rec = 4'b0000; ch_idle = 2'b00;
    step();
    chk("R4 enter_req low after ack", enter_req, 0);
    lp_ack = 1'b0;
    step();
    chk("R6 exit_req after busy", exit_req, 1);
    lp_ack = 1'b1;
    step();
    chk("R7 wake after exit ack", wake_pulse, 1);
    chk("R7 req_mode cleared", req_mode, 0);
    lp_ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 enter_req reset", enter_req, 0);
    chk("R1 exit_req reset", exit_req, 0);
    chk("R1 req_mode reset", req_mode, 0);
    chk("R1 wake reset", wake_pulse, 0);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < 11; i++) begin
      ch_idle  = VEC[i][8:7];
      mode_rec = VEC[i][6:3];
      step();
      chk("R2/R3 enter_req", enter_req, (VEC[i][2:0] != 0) ? 1 : 0);
      chk("R3 req_mode", req_mode, VEC[i][2:0]);
      if (VEC[i][2:0] != 0) leave_mode();
      else begin
        ch_idle = 2'b00; mode_rec = 4'b0000;
        step();
      end
    end

    // R10: stray ack with nothing pending
    lp_ack = 1'b1;
    step(); step();
    chk("R10 stray ack enter", enter_req, 0);
    chk("R10 stray ack exit", exit_req, 0);
    chk("R10 stray ack wake", wake_pulse, 0);
    lp_ack = 1'b0;

    // R4/R5: entry held, recommendation change ignored
    ch_idle = 2'b11; mode_rec = 4'b0001;
    step();
    chk("R4 enter_req raised", enter_req, 1);
    mode_rec = 4'b1000;
    step(); step();
    chk("R4 enter_req held", enter_req, 1);
    chk("R5 req_mode latched", req_mode, 1);
    // R8: deepening via exit then re-entry
    lp_ack = 1'b1;
    step();
    chk("R4 enter dropped", enter_req, 0);
    lp_ack = 1'b0;
    step();
    chk("R8 exit on deeper rec", exit_req, 1);
    chk("R8 code during exit", req_mode, 1);
    lp_ack = 1'b1;
    step();
    chk("R7 wake on deepen exit", wake_pulse, 1);
    lp_ack = 1'b0;
    step();
    chk("R8 re-enter deeper", enter_req, 1);
    chk("R8 deeper code", req_mode, 4);
    chk("R7 wake one cycle", wake_pulse, 0);
    lp_ack = 1'b1;
    step();
    lp_ack = 1'b0;
    // R8: shallower recommendation ignored
    mode_rec = 4'b0001;
    step(); step(); step();
    chk("R8 shallower no exit", exit_req, 0);
    chk("R8 resident code kept", req_mode, 4);
    // R6/R7: busy channel, exit held until ack
    ch_idle = 2'b10;
    step();
    chk("R6 exit on one busy channel", exit_req, 1);
    step(); step();
    chk("R7 exit held", exit_req, 1);
    chk("R9 no dual request", enter_req, 0);
    lp_ack = 1'b1;
    step();
    chk("R7 wake pulse", wake_pulse, 1);
    lp_ack = 1'b0;
    step();
    chk("R2 busy blocks entry", enter_req, 0);
    chk("R7 wake cleared", wake_pulse, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule